// File: doc/BRIEF.md
# Two-Way Registered Bus Transceiver

This block moves an 18-bit word between two ports, A and B, with one independent path per direction. Each path holds one word of storage, and two control inputs set how it works. While its pass enable is high, the path is transparent and the far port follows the near input in the same cycle. While its pass enable is low, the path drives its stored word. That word changes only when the path's strobe goes from high to low. Each path also has an output enable that decides whether the far port is driven at all. The A-to-B enable is active high and the B-to-A enable is active low.

The block belongs to a synchronous design. The strobes are sampled on the system clock, and a high-to-low strobe edge is detected between two rising clock edges. Each port comes out as a data vector plus a drive flag. This lets the surrounding logic build a tri-state pad or a bus multiplexer from it. An undriven port shows all zeros and a low drive flag. A synchronous active-low reset clears both stored words and the strobe history.

Top module: `bxcvr_top`

## Requirements
- R1: When a path's pass enable is high and its output is enabled, the far port equals the near input in the same cycle (B from A for A-to-B, A from B for B-to-A).
- R2: When a path's pass enable is low and its strobe does not fall, the stored word, and so the enabled far port, stays unchanged whatever the near input does.
- R3: When the pass enable is low and the strobe is sampled high at one rising clock edge and low at the next, the near input present at that second edge is stored and driven from then on.
- R4: A strobe rising from low to high never changes the stored word.
- R5: When the pass enable goes low, the path holds the near input that was sampled at the last rising clock edge where the pass enable was still high.
- R6: The A-to-B output enable is active high. While it is low, `b_drive` is 0 and `b_out` is all zeros, in every mode of the path.
- R7: The B-to-A output enable is active low. While it is high, `a_drive` is 0 and `a_out` is all zeros. While it is low, `a_drive` is 1.
- R8: Inputs and strobe activity on one path never change the stored word or the output of the other path.
- R9: A rising clock edge with `rst_n` low clears both stored words to zero and records both strobes as low. After reset, an enabled path with its pass enable low drives zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 18 | Word arriving on port A |
| b_in | input | 18 | Word arriving on port B |
| le_ab | input | 1 | A-to-B pass enable, high is transparent |
| le_ba | input | 1 | B-to-A pass enable, high is transparent |
| stb_ab | input | 1 | A-to-B capture strobe, acts on its falling edge |
| stb_ba | input | 1 | B-to-A capture strobe, acts on its falling edge |
| oe_ab | input | 1 | A-to-B output enable, active high |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| a_out | output | 18 | Word driven onto port A, zero when undriven |
| a_drive | output | 1 | High while port A is driven |
| b_out | output | 18 | Word driven onto port B, zero when undriven |
| b_drive | output | 1 | High while port B is driven |

## Verification
A stored word that is wrong stays hidden while the path is transparent or disabled. It shows up in the first cycle that the path is enabled with its pass enable low. For that reason the stimulus reads back after every pass-to-hold change and every strobe edge, in that same cycle and in the next. A missed or early capture shows at the port one clock after the falling strobe. A capture on a rising strobe or one that leaks across directions shows up when the held value is next read back. A polarity fault on either enable shows up in the same cycle as a drive flag that is wrong.

// File: rtl/bxcvr_pkg.sv
// Shared definitions for the two-way bus transceiver.
// Assumes: every path is the same width; the strobes are synchronous to clk.
package bxcvr_pkg;

    parameter int unsigned BXCVR_W = 18;

    // What the storage of one path does at the next rising clock edge.
    typedef enum logic [1:0] {
        PATH_HOLD    = 2'd0,
        PATH_PASS    = 2'd1,
        PATH_CAPTURE = 2'd2
    } path_act_e;

    // Picks the storage action from the pass enable and a detected falling strobe.
    function automatic path_act_e path_act(input logic pass_en, input logic stb_fall);
        if (pass_en)
            return PATH_PASS;
        else if (stb_fall)
            return PATH_CAPTURE;
        else
            return PATH_HOLD;
    endfunction

endpackage

// File: rtl/bxcvr_path.sv
// One direction of the transceiver: one word of storage with three modes.
// Pass enable high: the output follows the input, and the storage tracks it
// every clock. Pass enable low: the output is the stored word, which reloads
// only on a strobe that was high at the previous rising edge and is low now.
// Assumes: din, pass_en and stb change away from the rising edge of clk.
module bxcvr_path
    import bxcvr_pkg::*;
#(
    parameter int unsigned W = BXCVR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         pass_en,
    input  logic         stb,
    output logic [W-1:0] dout,
    output logic [W-1:0] held_o
);

    logic         stb_q;
    logic         stb_fall;
    logic [W-1:0] held_q;
    path_act_e    act;

    // Detects a high-to-low strobe between two samples and picks the action.
    always_comb begin
        stb_fall = stb_q & ~stb;
        act      = path_act(pass_en, stb_fall);
    end

    // Records the strobe level and reloads the stored word when asked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q  <= 1'b0;
            held_q <= '0;
        end else begin
            stb_q <= stb;
            if (act != PATH_HOLD)
                held_q <= din;
        end
    end

    // Sends the input straight through in pass mode, else the stored word.
    always_comb begin
        dout   = pass_en ? din : held_q;
        held_o = held_q;
    end

endmodule

// File: rtl/bxcvr_drive.sv
// Output stage for one port: turns the direction's output enable, whose
// polarity is set by EN_LOW, into a drive flag and gates the data to zero
// when the port is not driven.
// Assumes: the caller builds the pad or bus mux from out and drive.
module bxcvr_drive #(
    parameter int unsigned W      = bxcvr_pkg::BXCVR_W,
    parameter bit          EN_LOW = 1'b0
) (
    input  logic         oe,
    input  logic [W-1:0] data,
    output logic [W-1:0] out,
    output logic         drive
);

    logic en;

    generate
        if (EN_LOW) begin : g_low
            // Active-low enable.
            always_comb en = ~oe;
        end else begin : g_high
            // Active-high enable.
            always_comb en = oe;
        end
    endgenerate

    // Drives the data only while enabled.
    always_comb begin
        drive = en;
        out   = en ? data : '0;
    end

endmodule

// File: rtl/bxcvr_top.sv
// Two-way 18-bit transceiver: an A-to-B path and a B-to-A path, each with
// its own pass enable, capture strobe and output enable. Port A's enable is
// active low and port B's is active high.
// Assumes: the user never enables both directions onto a shared wire at once.
module bxcvr_top
    import bxcvr_pkg::*;
#(
    parameter int unsigned W = BXCVR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         le_ab,
    input  logic         le_ba,
    input  logic         stb_ab,
    input  logic         stb_ba,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    output logic [W-1:0] b_out,
    output logic         b_drive
);

    logic [W-1:0] ab_dat;
    logic [W-1:0] ab_held;
    logic [W-1:0] ba_dat;
    logic [W-1:0] ba_held;

    bxcvr_path #(.W(W)) path_ab_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (a_in),
        .pass_en (le_ab),
        .stb     (stb_ab),
        .dout    (ab_dat),
        .held_o  (ab_held)
    );

    bxcvr_path #(.W(W)) path_ba_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (b_in),
        .pass_en (le_ba),
        .stb     (stb_ba),
        .dout    (ba_dat),
        .held_o  (ba_held)
    );

    bxcvr_drive #(.W(W), .EN_LOW(1'b0)) drv_b_i (
        .oe    (oe_ab),
        .data  (ab_dat),
        .out   (b_out),
        .drive (b_drive)
    );

    bxcvr_drive #(.W(W), .EN_LOW(1'b1)) drv_a_i (
        .oe    (oe_ba_n),
        .data  (ba_dat),
        .out   (a_out),
        .drive (a_drive)
    );

endmodule

// File: rtl/bxcvr_chk.sv
// Property checker for bxcvr_top, attached by the bind below.
// Assumes: it is bound into bxcvr_top, so it can see the stored words.
module bxcvr_chk #(
    parameter int unsigned W = bxcvr_pkg::BXCVR_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         le_ab,
    input logic         le_ba,
    input logic         stb_ab,
    input logic         stb_ba,
    input logic         oe_ab,
    input logic         oe_ba_n,
    input logic [W-1:0] a_out,
    input logic         a_drive,
    input logic [W-1:0] b_out,
    input logic         b_drive,
    input logic [W-1:0] ab_held,
    input logic [W-1:0] ba_held
);

    AST_AB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_ab && le_ab) |-> (b_out == a_in)); // R1
    AST_BA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_ba_n && le_ba) |-> (a_out == b_in)); // R1
    AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ab && !$fell(stb_ab)) |=> $stable(ab_held)); // R2
    AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ba && !$fell(stb_ba)) |=> $stable(ba_held)); // R2
    AST_AB_SHOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_ab && !le_ab) |-> (b_out == ab_held)); // R2
    AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(stb_ab)) |=> (ab_held == $past(a_in))); // R3
    AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(stb_ba)) |=> (ba_held == $past(b_in))); // R3
    AST_AB_LOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        le_ab |=> (ab_held == $past(a_in))); // R5
    AST_B_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_ab |-> (!b_drive && b_out == '0)); // R6
    AST_A_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_ba_n |-> (!a_drive && a_out == '0)); // R7
    AST_A_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_ba_n |-> a_drive); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (ab_held == '0 && ba_held == '0)); // R9

endmodule

bind bxcvr_top bxcvr_chk #(.W(W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_in    (a_in),
    .b_in    (b_in),
    .le_ab   (le_ab),
    .le_ba   (le_ba),
    .stb_ab  (stb_ab),
    .stb_ba  (stb_ba),
    .oe_ab   (oe_ab),
    .oe_ba_n (oe_ba_n),
    .a_out   (a_out),
    .a_drive (a_drive),
    .b_out   (b_out),
    .b_drive (b_drive),
    .ab_held (ab_held),
    .ba_held (ba_held)
);

// File: tb/bxcvr_top_tb_top.sv
// Scoreboard bench for bxcvr_top. A driver sets the inputs at the falling
// clock edge. One ns later it works out the expected port values from a
// model built from the requirements and pushes them into a queue. A monitor
// pops each item and compares it with the ports.
module bxcvr_top_tb_top;

    localparam int unsigned W = 18;

    typedef struct {
        string        tag;
        logic [W-1:0] exp_a;
        logic         exp_ad;
        logic [W-1:0] exp_b;
        logic         exp_bd;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         le_ab = 1'b0;
    logic         le_ba = 1'b0;
    logic         stb_ab = 1'b0;
    logic         stb_ba = 1'b0;
    logic         oe_ab = 1'b0;
    logic         oe_ba_n = 1'b1;
    logic [W-1:0] a_out;
    logic         a_drive;
    logic [W-1:0] b_out;
    logic         b_drive;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb_q[$];
    event  chk_ev;

    // Model state, derived from R2, R3, R5 and R9.
    logic [W-1:0] m_ab = '0;
    logic [W-1:0] m_ba = '0;
    logic         m_sab = 1'b0;
    logic         m_sba = 1'b0;

    bxcvr_top #(.W(W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_in    (a_in),
        .b_in    (b_in),
        .le_ab   (le_ab),
        .le_ba   (le_ba),
        .stb_ab  (stb_ab),
        .stb_ba  (stb_ba),
        .oe_ab   (oe_ab),
        .oe_ba_n (oe_ba_n),
        .a_out   (a_out),
        .a_drive (a_drive),
        .b_out   (b_out),
        .b_drive (b_drive)
    );

    always #2.5 clk = ~clk;

    // Model update at each rising edge. The inputs are stable here because
    // they change only at the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ab = '0; m_ba = '0; m_sab = 1'b0; m_sba = 1'b0;
        end else begin
            if (le_ab || (m_sab && !stb_ab)) m_ab = a_in;
            if (le_ba || (m_sba && !stb_ba)) m_ba = b_in;
            m_sab = stb_ab;
            m_sba = stb_ba;
        end
    end

    // Pushes the expected port values for the present inputs.
    task automatic expect_now(input string tag);
        item_t it;
        #1;
        it.tag    = tag;
        it.exp_bd = oe_ab;
        it.exp_b  = oe_ab ? (le_ab ? a_in : m_ab) : '0;
        it.exp_ad = !oe_ba_n;
        it.exp_a  = !oe_ba_n ? (le_ba ? b_in : m_ba) : '0;
        sb_q.push_back(it);
        ->chk_ev;
    endtask

    // Monitor: compares every queued item with the ports.
    initial begin
        item_t it;
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if (a_out !== it.exp_a || a_drive !== it.exp_ad ||
                    b_out !== it.exp_b || b_drive !== it.exp_bd) begin
                    errors++;
                    $display("FAIL %s: actual a=%h/%b b=%h/%b expected a=%h/%b b=%h/%b",
                             it.tag, a_out, a_drive, b_out, b_drive,
                             it.exp_a, it.exp_ad, it.exp_b, it.exp_bd);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Driver: the stimulus sequence.
    initial begin
        logic [W-1:0] pats [4];
        pats[0] = 18'h3FFFF; pats[1] = 18'h12345; pats[2] = 18'h00000; pats[3] = 18'h2D2D2;

        // R9: reset with both outputs off, then read both stored words back.
        repeat (3) @(negedge clk);
        expect_now("R9 during reset");
        @(negedge clk); rst_n = 1'b1; oe_ab = 1'b1; expect_now("R9 B after reset");
        @(negedge clk); a_in = 18'h2AAAA; expect_now("R9 B ignores input");
        @(negedge clk); oe_ab = 1'b0; oe_ba_n = 1'b0; expect_now("R9 A after reset");
        @(negedge clk); oe_ba_n = 1'b1; oe_ab = 1'b1; le_ab = 1'b1;

        // R1: transparent A to B with several patterns.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); a_in = pats[i]; expect_now("R1 A-to-B pass");
        end

        // R5: pass enable falls while the input changes.
        @(negedge clk); le_ab = 1'b0; a_in = 18'h15555; expect_now("R5 hold at pass end");
        @(negedge clk); expect_now("R5 hold next cycle");

        // R2: strobe steady low, input changes.
        @(negedge clk); a_in = 18'h0A0A0; expect_now("R2 steady low");
        @(negedge clk); a_in = 18'h30303; expect_now("R2 steady low");

        // R4: rising strobe leaves storage alone.
        @(negedge clk); stb_ab = 1'b1; a_in = 18'h0F0F0; expect_now("R4 rising strobe");
        @(negedge clk); expect_now("R4 after rising edge");
        @(negedge clk); a_in = 18'h11111; expect_now("R2 steady high");

        // R3: falling strobe captures the input at that edge.
        @(negedge clk); stb_ab = 1'b0; a_in = 18'h3C3C3; expect_now("R3 before capture");
        @(negedge clk); a_in = 18'h00F00; expect_now("R3 captured");
        @(negedge clk); expect_now("R3 still held");
        @(negedge clk); stb_ab = 1'b1; a_in = 18'h22222; expect_now("R4 second rise");
        @(negedge clk); stb_ab = 1'b0; a_in = 18'h1ABCD; expect_now("R3 second fall");
        @(negedge clk); a_in = 18'h00001; expect_now("R3 second capture");

        // R6: B off in pass mode and in hold mode.
        @(negedge clk); oe_ab = 1'b0; le_ab = 1'b1; a_in = 18'h3FFFF; expect_now("R6 off in pass");
        @(negedge clk); le_ab = 1'b0; a_in = 18'h04444; expect_now("R6 off in hold");

        // R7 and R1: B to A path.
        @(negedge clk); oe_ba_n = 1'b0; le_ba = 1'b1; b_in = 18'h2468A; expect_now("R1 B-to-A pass");
        @(negedge clk); b_in = 18'h13579; expect_now("R7 A driven when low");
        @(negedge clk); oe_ba_n = 1'b1; expect_now("R7 A off when high");
        @(negedge clk); oe_ba_n = 1'b0; le_ba = 1'b0; b_in = 18'h3F000; expect_now("R5 B-to-A hold");
        @(negedge clk); stb_ba = 1'b1; b_in = 18'h00FFF; expect_now("R4 B-to-A rise");
        @(negedge clk); stb_ba = 1'b0; b_in = 18'h1F1F1; expect_now("R3 B-to-A fall");
        @(negedge clk); b_in = 18'h00000; expect_now("R3 B-to-A captured");

        // R8: A-to-B activity while A is driven, then read A-to-B back.
        @(negedge clk); stb_ab = 1'b0; a_in = 18'h35353; expect_now("R8 A held while A-to-B input moves");
        @(negedge clk); oe_ba_n = 1'b1; oe_ab = 1'b1; expect_now("R8 A-to-B word intact");
        @(negedge clk); le_ba = 1'b1; b_in = 18'h2BBBB; expect_now("R8 B-to-A pass no effect");
        @(negedge clk); le_ba = 1'b0; stb_ba = 1'b1; expect_now("R8 B-to-A strobe no effect");
        @(negedge clk); stb_ba = 1'b0; b_in = 18'h0CCCC; expect_now("R8 B-to-A capture no effect");
        @(negedge clk); oe_ab = 1'b0; oe_ba_n = 1'b0; expect_now("R8 B-to-A captured");

        // R9: reset in the middle of a run clears both words.
        @(negedge clk); rst_n = 1'b0; expect_now("R9 reset asserted");
        @(negedge clk); rst_n = 1'b1; expect_now("R9 A cleared");
        @(negedge clk); oe_ba_n = 1'b1; oe_ab = 1'b1; expect_now("R9 B cleared");

        @(negedge clk);
        #2;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule